// File: doc/BRIEF.md
# Code Prefetch Byte Queue

This block keeps a small window of instruction bytes between a code-fetch requester and a byte-wide linear memory read port. The requester asks for a byte, a word or a doubleword at a linear address. The block answers from its buffered bytes when enough of them remain. When none remain, it reloads the window from memory, starting at the requested address and running to the end of the aligned window. A read that runs past the end of the buffered bytes is answered in two pieces: first the bytes still held, then a reload at the next address, then the rest of the value, merged in little-endian order.

Fetches are expected to follow one another in address order. On a taken branch or a store into code, the requester pulses `flush`, which empties the queue so that the next fetch reloads. Segment limits, paging and faults belong to other blocks.

Top module: `code_prefetch_queue`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0, and the queue counts as empty.
- R2: A reload started at address A reads the linear addresses A up to A | (QLEN-1) once each, in ascending order, one byte per cycle in which `mem_req` and `mem_ack` are both high. The queue slot of an address is address & (QLEN-1), so a reload fetches QLEN - (A & (QLEN-1)) bytes.
- R3: A reload starts only when the remaining-byte count is zero or below. After a reload of N bytes, later fetches in address order cause no memory traffic until those N bytes have been used.
- R4: `req_size` encodes 2'b00 as a byte, 2'b01 as a word, 2'b10 or 2'b11 as a doubleword. `rsp_data` holds the byte at the request address in bits 7:0 and the following bytes above it, with unused upper bits zero.
- R5: A word fetch with one byte left returns that byte in bits 7:0, reloads starting at the address plus one, and returns the first byte of the new window in bits 15:8.
- R6: A doubleword fetch with 1, 2 or 3 bytes left returns those bytes in the low lanes, reloads starting at the first missing address, and fills the upper 3, 2 or 1 bytes from the new window starting at bit 8, 16 or 24.
- R7: A `flush` pulse sets the remaining count to zero, so the next fetch reloads even if bytes were left.
- R8: `req_ready` is low from the accepting cycle until the response. `rsp_valid` is high for exactly one cycle, and only after every reload for the request has finished.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req` and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the queue; pulsed only while no fetch is in flight |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can accept a fetch |
| req_addr | input | AW | Linear address of the fetch |
| req_size | input | 2 | Fetch size code (see R4) |
| rsp_valid | output | 1 | One-cycle pulse with the fetched value |
| rsp_data | output | 32 | Fetched value, little-endian, zero extended |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | AW | Linear address of the byte being read |
| mem_ack | input | 1 | Memory returns `mem_rdata` this cycle |
| mem_rdata | input | 8 | Byte read from memory |

## Verification
The embedded properties assume that fetches arrive in address order, or else after a flush, which keeps the reload window aligned so that a reload always ends on the last queue slot. They also assume that `flush` is pulsed only while `req_ready` is high and that the memory acknowledges only a pending request. The directed tasks issue each new fetch at the byte after the previous one, pulse `flush` only between fetches, and use a memory model that acknowledges every other cycle while `mem_req` is high, returning a byte computed from the address.

// File: rtl/cpq_pkg.sv
package cpq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } cpq_state_e;

  // Number of bytes named by a size code.
  function automatic logic [2:0] cpq_size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Bytes from slot (addr & (qlen-1)) to the end of the window.
  function automatic int cpq_fill_len(input logic [31:0] addr, input int qlen);
    return qlen - int'(addr & 32'(qlen - 1));
  endfunction

  // Place n bytes of piece into acc starting at byte lane at.
  function automatic logic [31:0] cpq_merge(input logic [31:0] acc,
                                            input logic [31:0] piece,
                                            input logic [2:0]  at,
                                            input logic [2:0]  n);
    logic [31:0] r;
    r = acc;
    for (int k = 0; k < 4; k++) begin
      int p;
      p = int'(at) + k;
      if (k < int'(n) && p < 4) r[p*8 +: 8] = piece[k*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cpq_store.sv
module cpq_store #(
  parameter int QLEN = 16,
  localparam int IW = $clog2(QLEN)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_bytes
);
  logic [7:0] slot_q [QLEN];

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_data;
  end

  // Four consecutive slots from rd_idx, wrapping at the window end.
  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [IW-1:0] lane_idx;
    assign lane_idx = rd_idx + IW'(k);
    assign rd_bytes[k*8 +: 8] = slot_q[lane_idx];
  end
endmodule

// File: rtl/cpq_count.sv
module cpq_count #(
  parameter int QLEN = 16,
  localparam int CW = $clog2(QLEN) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 load,
  input  logic [CW-1:0]        load_val,
  input  logic                 dec,
  input  logic [2:0]           dec_val,
  output logic signed [CW-1:0] remain,
  output logic                 empty
);
  logic signed [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (flush) cnt_q <= '0;
    else if (load)  cnt_q <= $signed(load_val);
    else if (dec)   cnt_q <= cnt_q - $signed(CW'(dec_val));
  end

  assign remain = cnt_q;
  assign empty  = (cnt_q <= 0);

  // R3: never consume more bytes than are held
  a_r3_dec_within: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> ($signed(CW'(dec_val)) <= cnt_q));
  // R3: a reload never claims more than a full window
  a_r3_load_range: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0 && load_val <= CW'(QLEN)));
  // R7: a flush leaves the queue empty
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == 0));
endmodule

// File: rtl/cpq_fill.sv
module cpq_fill
  import cpq_pkg::*;
#(
  parameter int QLEN = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(QLEN),
  localparam int CW  = IW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic [CW-1:0] fill_len
);
  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic [CW-1:0] len_q;
  logic          take;

  assign take = busy_q && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      addr_q <= start_addr;
      left_q <= CW'(cpq_fill_len(32'(start_addr), QLEN));
      len_q  <= CW'(cpq_fill_len(32'(start_addr), QLEN));
    end else if (take) begin
      addr_q <= addr_q + AW'(1);
      left_q <= left_q - CW'(1);
      if (left_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign mem_req  = busy_q;
  assign mem_addr = addr_q;
  assign wr_en    = take;
  assign wr_idx   = addr_q[IW-1:0];
  assign wr_data  = mem_rdata;
  assign done     = take && (left_q == CW'(1));
  assign fill_len = len_q;

  // R9: request and address hold until acknowledged
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R2: a reload always ends on the last slot of the window
  a_r2_fill_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_idx == IW'(QLEN - 1)));
  // R2: a reload is never restarted while one is running
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue
  import cpq_pkg::*;
#(
  parameter int QLEN = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(QLEN),
  localparam int CW  = IW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata
);
  cpq_state_e state_q, state_d;

  logic [AW-1:0] cur_addr_q;
  logic [2:0]    need_q;
  logic [2:0]    got_q;
  logic [31:0]   acc_q;

  // Named internal events
  logic                 accept;
  logic                 fill_start;
  logic                 fill_done;
  logic                 take_piece;
  logic [2:0]           piece_n;
  logic [2:0]           need_left;
  logic signed [CW-1:0] remain;
  logic                 q_empty;
  logic [CW-1:0]        fill_len;
  logic [31:0]          rd_bytes;
  logic                 wr_en;
  logic [IW-1:0]        wr_idx;
  logic [7:0]           wr_data;

  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign fill_start = (state_q == ST_SERVE) && q_empty;
  assign take_piece = (state_q == ST_SERVE) && !q_empty;
  assign need_left  = need_q - got_q;
  assign piece_n    = ($signed(CW'(need_left)) > remain) ? 3'(remain) : need_left;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SERVE;
      ST_SERVE: begin
        if (q_empty)                          state_d = ST_FILL;
        else if (got_q + piece_n == need_q)   state_d = ST_RESP;
      end
      ST_FILL:  if (fill_done) state_d = ST_SERVE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_addr_q <= '0;
      need_q     <= '0;
      got_q      <= '0;
      acc_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_addr_q <= req_addr;
        need_q     <= cpq_size_bytes(req_size);
        got_q      <= '0;
        acc_q      <= '0;
      end else if (take_piece) begin
        acc_q      <= cpq_merge(acc_q, rd_bytes, got_q, piece_n);
        got_q      <= got_q + piece_n;
        cur_addr_q <= cur_addr_q + AW'(piece_n);
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = acc_q;

  cpq_store #(.QLEN(QLEN)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (cur_addr_q[IW-1:0]),
    .rd_bytes (rd_bytes)
  );

  cpq_count #(.QLEN(QLEN)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (fill_done),
    .load_val (fill_len),
    .dec      (take_piece),
    .dec_val  (piece_n),
    .remain   (remain),
    .empty    (q_empty)
  );

  cpq_fill #(.QLEN(QLEN), .AW(AW)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fill_start),
    .start_addr (cur_addr_q),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .done       (fill_done),
    .fill_len   (fill_len)
  );

  // R8: one-cycle response, then ready again
  a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  // R8: no memory traffic outstanding when answering
  a_r8_rsp_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req);
  // R4: the answer carries exactly the requested number of bytes
  a_r4_full_value: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (got_q == need_q));
  // R3: memory is read only while the block is reloading
  a_r3_mem_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (state_q == ST_FILL));
  // R7: flush is only pulsed between fetches
  a_r7_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> req_ready);
endmodule

// File: tb/code_prefetch_queue_tb_top.sv
module code_prefetch_queue_tb_top;
  localparam int QLEN = 16;
  localparam int AW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [7:0]    mem_rdata;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  code_prefetch_queue #(.QLEN(QLEN), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] membyte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = membyte(mem_addr);

  // Memory model: acknowledge every other cycle while a request is pending.
  always @(negedge clk) mem_ack <= mem_req && !mem_ack;

  // Log of accepted memory bytes.
  int            hs_total = 0;
  logic [AW-1:0] hs_log [64];
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      hs_log[hs_total % 64] <= mem_addr;
      hs_total <= hs_total + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_flush();
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
  endtask

  // One fetch; checks value, handshake count, first reload address, order and R8.
  task automatic fetch(input logic [AW-1:0] a, input logic [1:0] sz,
                       input int exp_hs, input logic [AW-1:0] exp_first,
                       input string req);
    int nb;
    int start;
    int t;
    logic [31:0] exp;
    nb  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    exp = '0;
    for (int k = 0; k < nb; k++) exp[k*8 +: 8] = membyte(a + AW'(k));
    @(negedge clk);
    start     = hs_total;
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = sz;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R8 busy after accept"}, {31'd0, req_ready}, 32'd0);
    t = 0;
    while (!rsp_valid && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check({req, " R8 response seen"}, {31'd0, rsp_valid}, 32'd1);
    check({req, " R4 data"}, rsp_data, exp);
    check({req, " R3 reload bytes"}, 32'(hs_total - start), 32'(exp_hs));
    if (exp_hs > 0) begin
      check({req, " R2 reload start"}, hs_log[start % 64], exp_first);
      for (int k = 1; k < exp_hs; k++)
        check({req, " R2 ascending"}, hs_log[(start + k) % 64], exp_first + AW'(k));
    end
    @(negedge clk);
    check({req, " R8 single pulse"}, {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 mem_req",   {31'd0, mem_req},   32'd0);
  endtask

  task automatic t_sequential();
    // R2: first byte at slot 3 reloads 13 bytes 0x103..0x10F
    fetch(32'h103, 2'b00, 13, 32'h103, "R2 first byte");
    // R3: buffered bytes serve without traffic
    fetch(32'h104, 2'b01, 0, 32'h0, "R3 word hit");
    fetch(32'h106, 2'b10, 0, 32'h0, "R3 dword hit");
    fetch(32'h10A, 2'b11, 0, 32'h0, "R3 dword code3");
    fetch(32'h10E, 2'b01, 0, 32'h0, "R3 last word");
    // R3: exactly used up, now reload a full window
    fetch(32'h110, 2'b00, 16, 32'h110, "R3 empty reload");
  endtask

  task automatic t_word_split();
    pulse_flush();
    fetch(32'h21E, 2'b00, 2, 32'h21E, "R5 setup");
    fetch(32'h21F, 2'b01, 16, 32'h220, "R5 word split");
  endtask

  task automatic t_dword_split();
    for (int r = 1; r <= 3; r++) begin
      logic [AW-1:0] a0;
      a0 = 32'h300 + AW'(64 * r) + AW'(15 - r);
      pulse_flush();
      fetch(a0, 2'b00, r + 1, a0, "R6 setup");
      fetch(a0 + 1, 2'b10, 16, a0 + 1 + AW'(r), "R6 dword split");
    end
  endtask

  task automatic t_flush();
    pulse_flush();
    fetch(32'h505, 2'b00, 11, 32'h505, "R7 setup");
    fetch(32'h506, 2'b00, 0, 32'h0, "R7 no flush hit");
    pulse_flush();
    fetch(32'h507, 2'b01, 9, 32'h507, "R7 flush forces reload");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_word_split();
    t_dword_split();
    t_flush();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule